// File: doc/BRIEF.md
# Subroutine-Call Sequencer

This block is the part of a small processor's control unit that runs the instruction fetch and the subroutine call. It holds the program counter, the stack pointer and a temporary register. It also has a phase sequencer and a decoder that drives a set of named control strobes. Memory is attached through a single port that has an address, write data, read data, and read and write qualifiers. Read data must be valid in the same cycle that the address is presented.

Each fetch cycle reads the opcode at the program counter and steps the counter. When the opcode is the call opcode, two more phases follow.

- The first phase reads the target byte that follows the opcode into the temporary register. In the same cycle it advances the program counter past that byte and lowers the stack pointer.
- The second phase writes the return address at the new stack pointer and loads the program counter from the temporary register. It also flags itself as the last phase, so the next cycle is a fetch at the target.

The program counter and the stack pointer each have their own step circuit. Any other opcode is treated as a single-cycle instruction with no further effect.

Top module: `callseq_unit`

## Requirements
- R1: When reset is released, pc equals PC_RESET (0x00), sp equals SP_RESET (0x00), fetch is 1, and every st_* strobe, last_phase and mem_wr are 0.
- R2: In a fetch cycle, mem_addr equals pc and mem_rd is 1. At the following edge pc is incremented by one. A fetched opcode other than CALL_OP (0xC5) leads to another fetch cycle.
- R3: Fetching CALL_OP is followed by exactly two phases, then a fetch. last_phase is 1 only in the second phase.
- R4: In phase one, st_sp_dec, st_pc_b0, st_mem, st_ld, st_rx_load and st_pc_inc are 1, and st_pc_b1, st_sp_b0 and st_rx_to_pc are 0. mem_addr equals pc and mem_rd is 1.
- R5: At the end of phase one, sp is decremented by one and pc is incremented by one.
- R6: In phase two, st_pc_b1, st_sp_b0, st_mem and st_rx_to_pc are 1, and the other strobes are 0. mem_wr is 1, mem_addr equals sp and mem_wdata equals pc, which is the address two past the call opcode.
- R7: After phase two, pc equals the byte that was read in phase one.
- R8: During fetch, every st_* strobe is 0 and mem_wr is 0.
- R9: The stack grows downward and wraps. The first push after reset writes at 0xFF, and a nested call pushes at 0xFE.
- R10: mem_rd and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | W | Read data, valid in the same cycle as mem_addr |
| mem_addr | output | W | Memory address (bus0) |
| mem_wdata | output | W | Memory write data (bus1) |
| mem_rd | output | 1 | Memory read this cycle |
| mem_wr | output | 1 | Memory write at the next edge |
| fetch | output | 1 | Fetch cycle |
| last_phase | output | 1 | Final phase of a call |
| pc | output | W | Program counter |
| sp | output | W | Stack pointer |
| st_sp_dec | output | 1 | Stack pointer decrement |
| st_pc_b0 | output | 1 | Program counter drives bus0 |
| st_pc_b1 | output | 1 | Program counter drives bus1 |
| st_sp_b0 | output | 1 | Stack pointer drives bus0 |
| st_mem | output | 1 | Memory access |
| st_ld | output | 1 | Access is a read |
| st_rx_load | output | 1 | Temporary register latches read data |
| st_pc_inc | output | 1 | Program counter increment |
| st_rx_to_pc | output | 1 | Temporary register loads program counter |

## Verification
The assertions assume that mem_rdata is a pure function of mem_addr within a cycle. The target-load check relates pc to the read data seen two cycles earlier. The call-entry check assumes the opcode on mem_rdata during fetch is the one stored at pc. The bench meets both assumptions with a memory model that it reads combinationally and writes only on clock edges. It preloads a program with a plain opcode, a call and a nested call, and it never changes memory contents from outside the model.

// File: rtl/callseq_pkg.sv
package callseq_pkg;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_OPND  = 3'd1,
        PH_PUSH  = 3'd2
    } phase_e;

    typedef struct packed {
        logic sp_dec;
        logic pc_b0;
        logic pc_b1;
        logic sp_b0;
        logic mem;
        logic ld;
        logic rx_ld;
        logic pc_inc;
        logic rx_to_pc;
    } strobe_t;

endpackage

// File: rtl/callseq_incdec.sv
module callseq_incdec #(
    parameter int W    = 8,
    parameter bit DOWN = 1'b0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] ONE = W'(1);

    generate
        if (DOWN) begin : g_dec
            assign y = a - ONE;
        end else begin : g_inc
            assign y = a + ONE;
        end
    endgenerate
endmodule

// File: rtl/callseq_ctrl.sv
module callseq_ctrl
    import callseq_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] CALL_OP = 8'hC5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opcode,
    output strobe_t      strb,
    output logic         fetch,
    output logic         last
);
    typedef struct packed {
        phase_e ph;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d     = q;
        strb  = '0;
        fetch = 1'b0;
        last  = 1'b0;
        case (q.ph)
            PH_FETCH: begin
                fetch = 1'b1;
                if (opcode == CALL_OP) d.ph = PH_OPND;
            end
            PH_OPND: begin
                strb.sp_dec = 1'b1;
                strb.pc_b0  = 1'b1;
                strb.mem    = 1'b1;
                strb.ld     = 1'b1;
                strb.rx_ld  = 1'b1;
                strb.pc_inc = 1'b1;
                d.ph        = PH_PUSH;
            end
            PH_PUSH: begin
                strb.pc_b1    = 1'b1;
                strb.sp_b0    = 1'b1;
                strb.mem      = 1'b1;
                strb.rx_to_pc = 1'b1;
                last          = 1'b1;
                d.ph          = PH_FETCH;
            end
            default: d.ph = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.ph <= PH_FETCH;
        else        q    <= d;
    end
endmodule

// File: rtl/callseq_regs.sv
module callseq_regs
    import callseq_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] PC_RESET = '0,
    parameter logic [W-1:0] SP_RESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fetch,
    input  strobe_t      strb,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] pc,
    output logic [W-1:0] sp
);
    typedef struct packed {
        logic [W-1:0] pc;
        logic [W-1:0] sp;
        logic [W-1:0] rx;
    } regs_t;

    regs_t q, d;
    logic [W-1:0] pc_next1, sp_prev1;

    callseq_incdec #(.W(W), .DOWN(1'b0)) i_pc_step (.a(q.pc), .y(pc_next1));
    callseq_incdec #(.W(W), .DOWN(1'b1)) i_sp_step (.a(q.sp), .y(sp_prev1));

    always_comb begin
        d = q;
        if (fetch || strb.pc_inc) d.pc = pc_next1;
        if (strb.rx_to_pc)        d.pc = q.rx;
        if (strb.sp_dec)          d.sp = sp_prev1;
        if (strb.rx_ld)           d.rx = rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pc <= PC_RESET;
            q.sp <= SP_RESET;
            q.rx <= '0;
        end else begin
            q <= d;
        end
    end

    assign pc = q.pc;
    assign sp = q.sp;
endmodule

// File: rtl/callseq_unit.sv
module callseq_unit
    import callseq_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] CALL_OP  = 8'hC5,
    parameter logic [W-1:0] PC_RESET = '0,
    parameter logic [W-1:0] SP_RESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic         fetch,
    output logic         last_phase,
    output logic [W-1:0] pc,
    output logic [W-1:0] sp,
    output logic         st_sp_dec,
    output logic         st_pc_b0,
    output logic         st_pc_b1,
    output logic         st_sp_b0,
    output logic         st_mem,
    output logic         st_ld,
    output logic         st_rx_load,
    output logic         st_pc_inc,
    output logic         st_rx_to_pc
);
    strobe_t      strb;
    logic [W-1:0] bus0, bus1;

    callseq_ctrl #(.W(W), .CALL_OP(CALL_OP)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (mem_rdata),
        .strb   (strb),
        .fetch  (fetch),
        .last   (last_phase)
    );

    callseq_regs #(.W(W), .PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .fetch (fetch),
        .strb  (strb),
        .rdata (mem_rdata),
        .pc    (pc),
        .sp    (sp)
    );

    // bus0 carries the address: SP when selected, otherwise PC (fetch or pc_b0)
    assign bus0      = strb.sp_b0 ? sp : pc;
    assign bus1      = strb.pc_b1 ? pc : '0;
    assign mem_addr  = bus0;
    assign mem_wdata = bus1;
    assign mem_rd    = fetch || (strb.mem && strb.ld);
    assign mem_wr    = strb.mem && !strb.ld;

    assign st_sp_dec   = strb.sp_dec;
    assign st_pc_b0    = strb.pc_b0;
    assign st_pc_b1    = strb.pc_b1;
    assign st_sp_b0    = strb.sp_b0;
    assign st_mem      = strb.mem;
    assign st_ld       = strb.ld;
    assign st_rx_load  = strb.rx_ld;
    assign st_pc_inc   = strb.pc_inc;
    assign st_rx_to_pc = strb.rx_to_pc;
endmodule

// File: rtl/callseq_chk.sv
module callseq_chk #(
    parameter int           W       = 8,
    parameter logic [W-1:0] CALL_OP = 8'hC5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] mem_rdata,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic         fetch,
    input logic         last_phase,
    input logic [W-1:0] pc,
    input logic [W-1:0] sp,
    input logic         st_sp_dec,
    input logic         st_pc_b0,
    input logic         st_pc_b1,
    input logic         st_sp_b0,
    input logic         st_mem,
    input logic         st_ld,
    input logic         st_rx_load,
    input logic         st_pc_inc,
    input logic         st_rx_to_pc
);
    a_r2_fetch_steps_pc: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> (mem_rd && mem_addr == pc) ##1 (pc == $past(pc) + W'(1)));

    a_r3_call_enters_phase1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && mem_rdata == CALL_OP) |=> st_rx_load);

    a_r3_phase1_then_last: assert property (@(posedge clk) disable iff (!rst_n)
        st_rx_load |=> (last_phase && st_rx_to_pc));

    a_r3_last_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        last_phase |=> fetch);

    a_r5_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
        st_sp_dec |=> (sp == $past(sp) - W'(1)));

    a_r5_pc_up: assert property (@(posedge clk) disable iff (!rst_n)
        st_pc_inc |=> (pc == $past(pc) + W'(1)));

    a_r6_push_fields: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == sp && mem_wdata == pc));

    a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        st_rx_load |=> ##1 (pc == $past(mem_rdata, 2)));

    a_r8_quiet_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> !(st_sp_dec || st_pc_b0 || st_pc_b1 || st_sp_b0 || st_mem ||
                    st_ld || st_rx_load || st_pc_inc || st_rx_to_pc || mem_wr));

    a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
endmodule

bind callseq_unit callseq_chk #(.W(W), .CALL_OP(CALL_OP)) i_chk (.*);

// File: tb/test_callseq_unit.sv
module test_callseq_unit;
    localparam int          W  = 8;
    localparam logic [7:0]  OP = 8'hC5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_rdata, mem_addr, mem_wdata, pc, sp;
    logic       mem_rd, mem_wr, fetch, last_phase;
    logic       st_sp_dec, st_pc_b0, st_pc_b1, st_sp_b0, st_mem, st_ld;
    logic       st_rx_load, st_pc_inc, st_rx_to_pc;

    logic [7:0] mem [256];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    callseq_unit #(.W(W), .CALL_OP(OP)) i_callseq_unit (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    function automatic logic [8:0] strobes();
        return {st_sp_dec, st_pc_b0, st_pc_b1, st_sp_b0, st_mem, st_ld,
                st_rx_load, st_pc_inc, st_rx_to_pc};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        eq("R1", "pc", pc, 8'h00);
        eq("R1", "sp", sp, 8'h00);
        eq("R1", "fetch", fetch, 1);
        eq("R1", "strobes", {strobes(), last_phase, mem_wr}, 11'h0);
    endtask

    task automatic t_plain_fetch();
        eq("R2", "addr at fetch", mem_addr, 8'h00);
        eq("R2", "rd at fetch", mem_rd, 1);
        eq("R8", "quiet fetch", {strobes(), mem_wr}, 10'h0);
        step();
        eq("R2", "pc after fetch", pc, 8'h01);
        eq("R2", "still fetch", fetch, 1);
    endtask

    task automatic t_call(input logic [7:0] at, input logic [7:0] tgt,
                          input logic [7:0] sp_exp, input string rq);
        eq("R2", "fetch addr", mem_addr, at);
        eq("R10", "rd only", {mem_rd, mem_wr}, 2'b10);
        step();
        // phase one: strobe order sp_dec,pc_b0,pc_b1,sp_b0,mem,ld,rx_ld,pc_inc,rx_to_pc
        eq("R4", "phase1 strobes", strobes(), 9'b110011110);
        eq("R4", "phase1 addr", mem_addr, at + 8'd1);
        eq("R4", "phase1 rd", {mem_rd, mem_wr}, 2'b10);
        eq("R3", "phase1 not last", last_phase, 0);
        step();
        eq("R6", "phase2 strobes", strobes(), 9'b001110001);
        eq("R5", "pc advanced", pc, at + 8'd2);
        eq(rq, "sp lowered", sp, sp_exp);
        eq("R6", "push addr", mem_addr, sp_exp);
        eq("R6", "push data", mem_wdata, at + 8'd2);
        eq("R6", "write", {mem_rd, mem_wr}, 2'b01);
        eq("R3", "last", last_phase, 1);
        step();
        eq("R7", "pc target", pc, tgt);
        eq("R3", "back to fetch", fetch, 1);
        eq(rq, "stacked return", mem[sp_exp], at + 8'd2);
    endtask

    task automatic t_non_call();
        eq("R2", "fetch at target", mem_addr, 8'h80);
        step();
        eq("R2", "plain op single cycle", {fetch, pc}, {1'b1, 8'h81});
        eq("R8", "no strobes", strobes(), 9'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h01] = OP; mem[8'h02] = 8'h40;
        mem[8'h40] = OP; mem[8'h41] = 8'h80;
        mem[8'h80] = 8'h11;
        t_reset();
        t_plain_fetch();
        t_call(8'h01, 8'h40, 8'hFF, "R9");
        t_call(8'h40, 8'h80, 8'hFE, "R9");
        t_non_call();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule